// File: doc/BRIEF.md
# Channel Derandomizer with Rotating-Grant Readout

This block gathers digitized hit records from a bank of independent front-end channels and merges them onto one shared output stream. A hit shows up as a one-cycle write strobe on its channel, carrying a peak amplitude and a fine time value. Each channel keeps a small first-in first-out buffer of its own, so hits that arrive in bursts are absorbed locally and drained at the steady pace of the shared output.

A single grant pointer rotates around the channels, one position per cycle. When the pointer rests on a channel that holds a record, that channel gives its oldest record to the output register, and the word is tagged with the channel number. When the pointer rests on an empty channel, the pointer simply moves on. No trigger is involved: every stored record is drained as the pointer comes round. A valid/ready handshake on the output stops the pointer while the consumer stalls. A write that finds its channel buffer full is discarded and raises a sticky per-channel overflow flag, which only a global clear removes.

Top module: `token_ring_readout`

## Requirements
- R1: A synchronous active-high reset empties every channel buffer, clears all overflow flags, drops rd_valid, and leaves the grant pointer at channel 0 in the first cycle after reset.
- R2: An output word is {channel[5:0], amplitude[9:0], time[9:0]}: bits 25:20 hold the channel number, bits 19:10 the amplitude and bits 9:0 the time of the record.
- R3: Each channel stores up to 4 records and outputs them in the order they were written.
- R4: A write to a channel that already holds 4 records at the start of that cycle is discarded, even if the same channel is read out in that cycle, and the channel's overflow flag is 1 from the next cycle on.
- R5: An overflow flag stays set until ovf_clear is high at a clock edge, which clears every flag; a flag raised in the same cycle as the clear stays set.
- R6: Unless the output is stalled, the grant pointer moves to the next channel (wrapping from 63 to 0) on every clock edge; if the granted channel holds data, its oldest record appears on rd_word with rd_valid high after that edge, otherwise rd_valid is low after that edge. A channel therefore gives at most one word per pointer visit.
- R7: While rd_valid is high and rd_ready is low, rd_word, rd_valid and the grant pointer hold their values.
- R8: A stored record is output without any trigger or request input, within one pointer rotation of being written when the output is not stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_wr | input | 64 | Per-channel write strobe, bit n for channel n |
| hit_amp | input | 640 | Amplitudes, channel n in bits 10n+9:10n |
| hit_time | input | 640 | Fine times, channel n in bits 10n+9:10n |
| ovf_clear | input | 1 | Clears all overflow flags |
| rd_ready | input | 1 | Consumer accepts rd_word when high |
| rd_valid | output | 1 | rd_word holds a record |
| rd_word | output | 26 | Tagged record {channel, amplitude, time} |
| ovf_sticky | output | 64 | Sticky per-channel overflow flags |

## Verification
A write strobe sampled at edge k changes the channel's occupancy at that edge, so the earliest readout is at the first later edge where the pointer sits on that channel; the word and rd_valid are then visible right after that edge, and an overflow flag or its clear is visible one edge after the offending write or the clear. Inputs are driven 5 ns after a rising edge and outputs are compared at the falling edge, against a cycle-by-cycle reference built from the requirements that advances on the same rising edges. Directed checks count edges explicitly: after reset a record on channel 2 must be absent after two edges and present after the third, and a stalled word must reappear unchanged at the next falling edge.

// File: rtl/ring_pkg.sv
package ring_pkg;

  localparam int DEF_CHANNELS = 64;
  localparam int DEF_DEPTH    = 4;
  localparam int DEF_AMP_W    = 10;
  localparam int DEF_TIME_W   = 10;

  // width needed to index n items, never below 1
  function automatic int index_w(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/chan_fifo.sv
module chan_fifo #(
  parameter int DW    = 20,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  input  logic          ovf_clear,
  output logic [DW-1:0] dout,
  output logic          nonempty,
  output logic          full,
  output logic          ovf
);
  import ring_pkg::*;

  localparam int PW = index_w(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign full     = (count == CW'(DEPTH));
  assign nonempty = (count != '0);
  assign push_ok  = push && !full;
  assign pop_ok   = pop && nonempty;
  assign dout     = mem[rptr];

  // storage without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // sticky drop flag; a new drop wins over a clear
  always_ff @(posedge clk) begin
    if (rst)               ovf <= 1'b0;
    else if (push && full) ovf <= 1'b1;
    else if (ovf_clear)    ovf <= 1'b0;
  end

endmodule

// File: rtl/token_ring.sv
module token_ring #(
  parameter int N  = 64,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          advance,
  output logic [CW-1:0] tok
);

  always_ff @(posedge clk) begin
    if (rst)          tok <= '0;
    else if (advance) tok <= (tok == CW'(N - 1)) ? '0 : tok + 1'b1;
  end

endmodule

// File: rtl/token_ring_readout.sv
module token_ring_readout #(
  parameter int NUM_CH = ring_pkg::DEF_CHANNELS,
  parameter int DEPTH  = ring_pkg::DEF_DEPTH,
  parameter int AMP_W  = ring_pkg::DEF_AMP_W,
  parameter int TIME_W = ring_pkg::DEF_TIME_W
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [NUM_CH-1:0]                      hit_wr,
  input  logic [NUM_CH*AMP_W-1:0]                hit_amp,
  input  logic [NUM_CH*TIME_W-1:0]               hit_time,
  input  logic                                   ovf_clear,
  input  logic                                   rd_ready,
  output logic                                   rd_valid,
  output logic [$clog2(NUM_CH)+AMP_W+TIME_W-1:0] rd_word,
  output logic [NUM_CH-1:0]                      ovf_sticky
);

  localparam int CH_W  = $clog2(NUM_CH);
  localparam int DW    = AMP_W + TIME_W;
  localparam int OUT_W = CH_W + DW;

  logic [CH_W-1:0]   tok_ptr;
  logic [NUM_CH-1:0] ch_nonempty, ch_full, ch_pop;
  logic [DW-1:0]     ch_head [NUM_CH];
  logic [DW-1:0]     sel_head;
  logic              sel_nonempty;
  logic              step;
  logic              valid_q;
  logic [OUT_W-1:0]  word_q;

  // the pointer moves unless a presented word waits for the consumer
  assign step = !valid_q || rd_ready;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_pop[i] = step && (tok_ptr == CH_W'(i));
    chan_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst      (rst),
      .push     (hit_wr[i]),
      .din      ({hit_amp[i*AMP_W +: AMP_W], hit_time[i*TIME_W +: TIME_W]}),
      .pop      (ch_pop[i]),
      .ovf_clear(ovf_clear),
      .dout     (ch_head[i]),
      .nonempty (ch_nonempty[i]),
      .full     (ch_full[i]),
      .ovf      (ovf_sticky[i])
    );
  end

  assign sel_head     = ch_head[tok_ptr];
  assign sel_nonempty = ch_nonempty[tok_ptr];

  token_ring #(.N(NUM_CH), .CW(CH_W)) u_ring (
    .clk    (clk),
    .rst    (rst),
    .advance(step),
    .tok    (tok_ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else if (step) begin
      valid_q <= sel_nonempty;
      if (sel_nonempty) word_q <= {tok_ptr, sel_head};
    end
  end

  assign rd_valid = valid_q;
  assign rd_word  = word_q;

endmodule

// File: rtl/ring_chk.sv
module ring_chk #(
  parameter int N     = 64,
  parameter int CH_W  = 6,
  parameter int OUT_W = 26
) (
  input logic             clk,
  input logic             rst,
  input logic [N-1:0]     hit_wr,
  input logic             ovf_clear,
  input logic             rd_ready,
  input logic             rd_valid,
  input logic [OUT_W-1:0] rd_word,
  input logic [N-1:0]     ovf_sticky,
  input logic [CH_W-1:0]  tok,
  input logic [N-1:0]     nonempty,
  input logic [N-1:0]     full
);

  function automatic logic [CH_W-1:0] ring_next(input logic [CH_W-1:0] t);
    return (t == CH_W'(N - 1)) ? '0 : t + 1'b1;
  endfunction

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: state right after reset
  always_ff @(posedge clk) begin
    if (rst_d && !rst) begin
      assert_reset_state_R1: assert (!rd_valid && tok == '0 && ovf_sticky == '0 && nonempty == '0)
        else $error("reset state wrong");
    end
  end

  assert_grant_tag_R2: assert property (@(posedge clk) disable iff (rst)
    (!rd_valid || rd_ready) && nonempty[tok] |=> rd_valid && rd_word[OUT_W-1 -: CH_W] == $past(tok));

  assert_drop_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (hit_wr & full) != '0 |=> (ovf_sticky & $past(hit_wr & full)) == $past(hit_wr & full));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    !ovf_clear |=> (ovf_sticky & $past(ovf_sticky)) == $past(ovf_sticky));

  assert_token_step_R6: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && !rd_ready) |=> tok == ring_next($past(tok)));

  assert_empty_skip_R6: assert property (@(posedge clk) disable iff (rst)
    (!rd_valid || rd_ready) && !nonempty[tok] |=> !rd_valid);

  assert_hold_word_R7: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_word) && $stable(tok));

endmodule

bind token_ring_readout ring_chk #(.N(NUM_CH), .CH_W(CH_W), .OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hit_wr    (hit_wr),
  .ovf_clear (ovf_clear),
  .rd_ready  (rd_ready),
  .rd_valid  (rd_valid),
  .rd_word   (rd_word),
  .ovf_sticky(ovf_sticky),
  .tok       (tok_ptr),
  .nonempty  (ch_nonempty),
  .full      (ch_full)
);

// File: tb/sim_token_ring_readout.sv
module sim_token_ring_readout;
  localparam int N  = 64;
  localparam int D  = 4;
  localparam int AW = 10;
  localparam int TW = 10;
  localparam int CW = 6;
  localparam int OW = CW + AW + TW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    hit_wr = '0;
  logic [N*AW-1:0] hit_amp = '0;
  logic [N*TW-1:0] hit_time = '0;
  logic ovf_clear = 1'b0;
  logic rd_ready = 1'b1;
  logic rd_valid;
  logic [OW-1:0] rd_word;
  logic [N-1:0] ovf_sticky;

  token_ring_readout u0 (
    .clk(clk), .rst(rst), .hit_wr(hit_wr), .hit_amp(hit_amp), .hit_time(hit_time),
    .ovf_clear(ovf_clear), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_word(rd_word), .ovf_sticky(ovf_sticky)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  bit run_mon = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference built from the requirements, advanced on each rising edge
  int m_cnt [N];
  logic [AW+TW-1:0] m_q [N][D];
  int m_tok;
  logic m_v;
  logic [OW-1:0] m_w;
  logic [N-1:0] m_ovf;
  bit m_full [N];

  always @(posedge clk) begin
    if (rst) begin
      m_tok = 0; m_v = 1'b0; m_w = '0; m_ovf = '0;
      for (int c = 0; c < N; c++) m_cnt[c] = 0;
    end else begin
      for (int c = 0; c < N; c++) m_full[c] = (m_cnt[c] == D);
      if (!(m_v && !rd_ready)) begin
        if (m_cnt[m_tok] > 0) begin
          m_w = {CW'(m_tok), m_q[m_tok][0]};
          for (int k = 0; k < D - 1; k++) m_q[m_tok][k] = m_q[m_tok][k+1];
          m_cnt[m_tok]--;
          m_v = 1'b1;
        end else m_v = 1'b0;
        m_tok = (m_tok + 1) % N;
      end
      if (ovf_clear) m_ovf = '0;
      for (int c = 0; c < N; c++) begin
        if (hit_wr[c]) begin
          if (m_full[c]) m_ovf[c] = 1'b1;
          else begin
            m_q[c][m_cnt[c]] = {hit_amp[c*AW +: AW], hit_time[c*TW +: TW]};
            m_cnt[c]++;
          end
        end
      end
    end
  end

  // monitor at the falling edge
  bit stall_prev = 1'b0;
  logic [OW-1:0] stall_word;
  int cnt5 = 0;
  int seen40 = 0;
  always @(negedge clk) begin
    if (!rst && run_mon) begin
      check(rd_valid === m_v, cur_req, 64'(rd_valid), 64'(m_v));
      if (m_v) check(rd_word === m_w, cur_req, 64'(rd_word), 64'(m_w));
      check(ovf_sticky === m_ovf, cur_req, 64'(ovf_sticky), 64'(m_ovf));
      if (stall_prev) check(rd_valid && rd_word === stall_word, "R7", 64'(rd_word), 64'(stall_word));
      stall_prev = rd_valid && !rd_ready;
      stall_word = rd_word;
      if (rd_valid && rd_ready && rd_word[OW-1 -: CW] == 6'd5) cnt5++;
      if (rd_valid && rd_ready && rd_word == {6'd40, 10'h2a5, 10'h15a}) seen40++;
    end
  end

  task automatic step();
    @(posedge clk);
    #5;
    hit_wr = '0;
    ovf_clear = 1'b0;
  endtask

  task automatic put(input int ch, input logic [AW-1:0] a, input logic [TW-1:0] t);
    hit_wr[ch] = 1'b1;
    hit_amp[ch*AW +: AW] = a;
    hit_time[ch*TW +: TW] = t;
  endtask

  task automatic wait_valid();
    for (int k = 0; k < 200; k++) begin
      if (rd_valid) break;
      step();
    end
  endtask

  // {channel, amplitude, time, ready}
  localparam logic [26:0] VEC [16] = '{
    {6'd3,  10'h011, 10'h022, 1'b1}, {6'd3,  10'h033, 10'h044, 1'b1},
    {6'd63, 10'h3ff, 10'h000, 1'b1}, {6'd0,  10'h000, 10'h3ff, 1'b0},
    {6'd17, 10'h155, 10'h2aa, 1'b0}, {6'd17, 10'h2aa, 10'h155, 1'b1},
    {6'd33, 10'h101, 10'h202, 1'b1}, {6'd1,  10'h0f0, 10'h00f, 1'b0},
    {6'd2,  10'h123, 10'h321, 1'b1}, {6'd3,  10'h055, 10'h066, 1'b1},
    {6'd48, 10'h3c3, 10'h0c3, 1'b0}, {6'd62, 10'h001, 10'h002, 1'b1},
    {6'd62, 10'h003, 10'h004, 1'b1}, {6'd62, 10'h005, 10'h006, 1'b0},
    {6'd9,  10'h1e1, 10'h2d2, 1'b1}, {6'd10, 10'h0aa, 10'h0bb, 1'b1}
  };

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    rst = 1'b0;
    // R1: reset state at the ports
    check(rd_valid === 1'b0, "R1", 64'(rd_valid), 64'd0);
    check(ovf_sticky === '0, "R1", 64'(ovf_sticky), 64'd0);
    run_mon = 1'b1;
    // R1: pointer at channel 0 after reset reaches channel 2 on the third edge
    put(2, 10'h2c1, 10'h1c2);
    step();
    step();
    check(rd_valid === 1'b0, "R1", 64'(rd_valid), 64'd0);
    step();
    check(rd_valid === 1'b1 && rd_word === {6'd2, 10'h2c1, 10'h1c2}, "R1", 64'(rd_word), 64'({6'd2, 10'h2c1, 10'h1c2}));

    // R2 R6 R8: table of writes with mixed ready
    cur_req = "R6";
    for (int i = 0; i < 16; i++) begin
      put(int'(VEC[i][26:21]), VEC[i][20:11], VEC[i][10:1]);
      rd_ready = VEC[i][0];
      step();
    end
    rd_ready = 1'b1;
    cur_req = "R2";
    repeat (140) step();

    // R3 R4: overfill channel 5 while the output is stalled
    cur_req = "R4";
    put(2, 10'h001, 10'h001);
    rd_ready = 1'b0;
    step();
    wait_valid();
    for (int k = 0; k < 6; k++) begin
      put(5, 10'(k + 16), 10'(k + 32));
      step();
    end
    check(ovf_sticky[5] === 1'b1, "R4", 64'(ovf_sticky), 64'(1) << 5);
    cnt5 = 0;
    cur_req = "R3";
    rd_ready = 1'b1;
    repeat (300) step();
    check(cnt5 == D, "R3", 64'(cnt5), 64'(D));

    // R5: clear, then a drop in the same cycle as a clear
    cur_req = "R5";
    ovf_clear = 1'b1;
    step();
    check(ovf_sticky === '0, "R5", 64'(ovf_sticky), 64'd0);
    put(9, 10'h002, 10'h002);
    rd_ready = 1'b0;
    step();
    wait_valid();
    for (int k = 0; k < D; k++) begin
      put(7, 10'(k), 10'(k));
      step();
    end
    put(7, 10'h3aa, 10'h3bb);
    ovf_clear = 1'b1;
    step();
    check(ovf_sticky === (64'd1 << 7), "R5", 64'(ovf_sticky), 64'd1 << 7);
    repeat (3) step();
    check(ovf_sticky === (64'd1 << 7), "R5", 64'(ovf_sticky), 64'd1 << 7);
    ovf_clear = 1'b1;
    step();
    check(ovf_sticky === '0, "R5", 64'(ovf_sticky), 64'd0);
    rd_ready = 1'b1;
    repeat (140) step();

    // R7: all channels written twice, consumer stalls one cycle in three
    cur_req = "R7";
    for (int r = 0; r < 2; r++) begin
      for (int c = 0; c < N; c++) put(c, 10'(c * 3 + r), 10'(1023 - c - r));
      step();
    end
    for (int k = 0; k < 400; k++) begin
      rd_ready = (k % 3) != 0;
      step();
    end
    rd_ready = 1'b1;
    repeat (140) step();

    // R8: a lone record drains with no other input
    cur_req = "R8";
    seen40 = 0;
    put(40, 10'h2a5, 10'h15a);
    step();
    repeat (N + 2) step();
    check(seen40 == 1, "R8", 64'(seen40), 64'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule